// File: doc/BRIEF.md
# Single-Cycle 32-bit Integer Core

This block is a compact 32-bit processor core that finishes every instruction in exactly one clock. Each cycle it fetches a word from its instruction store at the program counter and decodes it. It reads two source registers and runs one arithmetic or logic operation. It may then touch its data store. On the rising edge it commits a register write, a memory write and the next program counter.

The core runs nine instructions. Five are register-to-register operations: add, subtract, bitwise and, bitwise or, and signed set-less-than. The other four are load word, store word, branch-if-equal and an absolute jump. The branch is resolved from the ALU zero flag. Any other encoding is treated as a no-operation.

The core's only operating inputs are clock and reset. A load port fills the instruction store at any time, and it fills the data store while reset is held. Debug outputs show the program counter and the write traffic to the register file and the data store.

Top module: `scyc_core`

## Requirements
- R1: While rst_n is low, dbg_pc reads 0, dbg_rf_we and dbg_dm_we stay low, and all 32 registers are cleared. The first instruction after reset is fetched from byte address 0.
- R2: For every instruction other than a taken branch or a jump, the program counter advances by 4 on each clock. The program counter is always a multiple of 4.
- R3: Register operations use opcode 0 in bits 31:26. The sources are rs (bits 25:21) and rt (bits 20:16), and the result goes to rd (bits 15:11). Funct (bits 5:0) selects the operation: 0x20 adds, 0x22 subtracts (rs minus rt), 0x24 is bitwise and, and 0x25 is bitwise or.
- R4: Funct 0x2A writes 1 to rd when rs is less than rt as signed 32-bit numbers. Otherwise it writes 0.
- R5: Register 0 always reads as zero. A write aimed at it has no effect.
- R6: Load word (opcode 0x23) reads the data word at rs plus the sign-extended 16-bit offset (bits 15:0) and writes it to rt.
- R7: Store word (opcode 0x2B) writes rt to the data word at rs plus the sign-extended offset. It does not write any register.
- R8: Branch-if-equal (opcode 0x04) sets the PC to PC+4 plus the sign-extended offset shifted left by 2 when rs equals rt. Otherwise it sets the PC to PC+4. It writes neither a register nor memory.
- R9: Jump (opcode 0x02) sets the PC to the top 4 bits of PC+4 followed by the 26-bit index (bits 25:0) shifted left by 2.
- R10: An unknown opcode, or opcode 0 with an unknown funct, writes neither a register nor memory, and the PC advances by 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| load_en | input | 1 | Writes load_word into the store chosen by load_dmem |
| load_dmem | input | 1 | 0 targets the instruction store; 1 targets the data store (acts only during reset) |
| load_addr | input | log2(MEM_WORDS) | Word index for the load write |
| load_word | input | 32 | Word to be loaded |
| dbg_pc | output | 32 | Current program counter (byte address) |
| dbg_rf_we | output | 1 | Register write committed at the next edge |
| dbg_rf_waddr | output | 5 | Destination register of that write |
| dbg_rf_wdata | output | 32 | Value being written to the register |
| dbg_dm_we | output | 1 | Store committed at the next edge |
| dbg_dm_addr | output | 32 | ALU result; the byte address for loads and stores |
| dbg_dm_wdata | output | 32 | Value being stored |

## Verification
The hardest behaviour to reach is a backward branch taken many times in a row. That needs a value that changes across iterations, yet the core has no immediate-arithmetic instruction. The stimulus therefore preloads constants into the data store during reset, loads them into registers, and builds a counter from a set-less-than result of 1. A branch with a negative offset then loops until a signed compare fails. The same program covers the other hard cases: it stores to a negative offset and loads the value back, writes register 0 and then reads it, and runs encodings that must change nothing.

// File: rtl/scyc_pkg.sv
// Package scyc_pkg: shared encodings and the decoded control bundle for the
// single-cycle core. Opcode and funct values are architectural; ALU codes are
// the internal selector between decoder and ALU.
package scyc_pkg;

    typedef enum logic [2:0] {
        ALU_AND = 3'b000,
        ALU_OR  = 3'b001,
        ALU_ADD = 3'b010,
        ALU_SUB = 3'b110,
        ALU_SLT = 3'b111
    } alu_op_e;

    localparam logic [5:0] OP_REG   = 6'h00;
    localparam logic [5:0] OP_LOADW = 6'h23;
    localparam logic [5:0] OP_STORW = 6'h2B;
    localparam logic [5:0] OP_BREQ  = 6'h04;
    localparam logic [5:0] OP_JUMP  = 6'h02;

    localparam logic [5:0] FN_ADD = 6'h20;
    localparam logic [5:0] FN_SUB = 6'h22;
    localparam logic [5:0] FN_AND = 6'h24;
    localparam logic [5:0] FN_OR  = 6'h25;
    localparam logic [5:0] FN_SLT = 6'h2A;

    typedef struct packed {
        logic    rf_we;     // commit a register write
        logic    dst_rd;    // destination is rd (else rt)
        logic    alu_imm;   // second ALU operand is the extended offset
        logic    mem_we;    // commit a data-store write
        logic    mem_re;    // write-back value comes from the data store
        logic    branch;    // conditional branch on ALU zero
        logic    jump;      // absolute jump
        alu_op_e alu_op;
    } ctrl_t;

endpackage

// File: rtl/scyc_decode.sv
// Module scyc_decode: main decoder plus ALU decoder, purely combinational.
// Assumes: unknown opcodes/functs must be harmless, so they decode to all-zero
// control (no writes, no control transfer).
module scyc_decode
    import scyc_pkg::*;
(
    input  logic [5:0] opcode,
    input  logic [5:0] funct,
    output ctrl_t      ctrl
);

    // Map opcode/funct to the control bundle.
    always_comb begin
        ctrl        = '0;
        ctrl.alu_op = ALU_ADD;
        case (opcode)
            OP_REG: begin
                ctrl.dst_rd = 1'b1;
                ctrl.rf_we  = 1'b1;
                case (funct)
                    FN_ADD:  ctrl.alu_op = ALU_ADD;
                    FN_SUB:  ctrl.alu_op = ALU_SUB;
                    FN_AND:  ctrl.alu_op = ALU_AND;
                    FN_OR:   ctrl.alu_op = ALU_OR;
                    FN_SLT:  ctrl.alu_op = ALU_SLT;
                    default: ctrl.rf_we  = 1'b0;
                endcase
            end
            OP_LOADW: begin
                ctrl.rf_we   = 1'b1;
                ctrl.alu_imm = 1'b1;
                ctrl.mem_re  = 1'b1;
            end
            OP_STORW: begin
                ctrl.alu_imm = 1'b1;
                ctrl.mem_we  = 1'b1;
            end
            OP_BREQ: begin
                ctrl.branch = 1'b1;
                ctrl.alu_op = ALU_SUB;
            end
            OP_JUMP: ctrl.jump = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/scyc_alu.sv
// Module scyc_alu: W-bit ALU with and/or/add/sub/signed-less-than and a zero
// flag. Assumes op is one of the scyc_pkg codes; others yield zero.
module scyc_alu
    import scyc_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  alu_op_e      op,
    output logic [W-1:0] y,
    output logic         zero
);

    // Select the operation result.
    always_comb begin
        case (op)
            ALU_AND: y = a & b;
            ALU_OR:  y = a | b;
            ALU_ADD: y = a + b;
            ALU_SUB: y = a - b;
            ALU_SLT: y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
            default: y = '0;
        endcase
    end

    assign zero = (y == '0);

endmodule

// File: rtl/scyc_regfile.sv
// Module scyc_regfile: 2-read/1-write register file, reads combinational,
// write on rising edge. Entry 0 is hard-wired to zero. Cleared on reset.
module scyc_regfile #(
    parameter int W     = 32,
    parameter int NREGS = 32,
    localparam int RW   = $clog2(NREGS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [RW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [RW-1:0] ra0,
    output logic [W-1:0]  rd0,
    input  logic [RW-1:0] ra1,
    output logic [W-1:0]  rd1
);

    logic [W-1:0] regs [NREGS];

    // Clear on reset, otherwise commit the write unless it targets entry 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREGS; i++) regs[i] <= '0;
        end else if (we && (waddr != '0)) begin
            regs[waddr] <= wdata;
        end
    end

    assign rd0 = (ra0 == '0) ? '0 : regs[ra0];
    assign rd1 = (ra1 == '0) ? '0 : regs[ra1];

endmodule

// File: rtl/scyc_ram.sv
// Module scyc_ram: word-wide storage, combinational read, write on rising
// edge. No reset; contents are whatever was last written.
module scyc_ram #(
    parameter int W     = 32,
    parameter int DEPTH = 64,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);

    logic [W-1:0] mem [DEPTH];

    // Commit one word per enabled edge.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/scyc_core.sv
// Module scyc_core: single-cycle 32-bit core. Fetch, decode, register read,
// ALU, data access and write-back all happen inside one clock; PC, register
// file and data store update together on the rising edge.
// Assumes: programs are loaded through the load port (instruction store at
// any time, data store only while rst_n is low); addresses are word aligned.
module scyc_core
    import scyc_pkg::*;
#(
    parameter int MEM_WORDS = 64
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         load_en,
    input  logic                         load_dmem,
    input  logic [$clog2(MEM_WORDS)-1:0] load_addr,
    input  logic [31:0]                  load_word,
    output logic [31:0]                  dbg_pc,
    output logic                         dbg_rf_we,
    output logic [4:0]                   dbg_rf_waddr,
    output logic [31:0]                  dbg_rf_wdata,
    output logic                         dbg_dm_we,
    output logic [31:0]                  dbg_dm_addr,
    output logic [31:0]                  dbg_dm_wdata
);

    localparam int AW = $clog2(MEM_WORDS);
    localparam int XW = 32;

    logic [XW-1:0] pc_q, pc_next, pc_seq, br_tgt, jmp_tgt;
    logic [XW-1:0] instr, rs_val, rt_val, imm_ext, br_off;
    logic [XW-1:0] alu_b, alu_y, dm_rdata, wb_data;
    logic          alu_zero, rf_we, core_dm_we, dm_we;
    logic [4:0]    rf_waddr;
    logic [AW-1:0] dm_waddr;
    logic [XW-1:0] dm_wdata;
    ctrl_t         ctrl;

    // Instruction store: written by the load port, read at the PC.
    scyc_ram #(.W(XW), .DEPTH(MEM_WORDS)) imem_i (
        .clk   (clk),
        .we    (load_en && !load_dmem),
        .waddr (load_addr),
        .wdata (load_word),
        .raddr (pc_q[AW+1:2]),
        .rdata (instr)
    );

    scyc_decode dec_i (
        .opcode (instr[31:26]),
        .funct  (instr[5:0]),
        .ctrl   (ctrl)
    );

    assign rf_we    = ctrl.rf_we && rst_n;
    assign rf_waddr = ctrl.dst_rd ? instr[15:11] : instr[20:16];
    assign wb_data  = ctrl.mem_re ? dm_rdata : alu_y;

    scyc_regfile #(.W(XW), .NREGS(32)) rf_i (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (rf_we),
        .waddr (rf_waddr),
        .wdata (wb_data),
        .ra0   (instr[25:21]),
        .rd0   (rs_val),
        .ra1   (instr[20:16]),
        .rd1   (rt_val)
    );

    assign imm_ext = {{16{instr[15]}}, instr[15:0]};
    assign br_off  = {{14{instr[15]}}, instr[15:0], 2'b00};
    assign alu_b   = ctrl.alu_imm ? imm_ext : rt_val;

    scyc_alu #(.W(XW)) alu_i (
        .a    (rs_val),
        .b    (alu_b),
        .op   (ctrl.alu_op),
        .y    (alu_y),
        .zero (alu_zero)
    );

    // Data store: core stores when running, load port while in reset.
    assign core_dm_we = ctrl.mem_we && rst_n;
    assign dm_we      = rst_n ? core_dm_we : (load_en && load_dmem);
    assign dm_waddr   = rst_n ? alu_y[AW+1:2] : load_addr;
    assign dm_wdata   = rst_n ? rt_val : load_word;

    scyc_ram #(.W(XW), .DEPTH(MEM_WORDS)) dmem_i (
        .clk   (clk),
        .we    (dm_we),
        .waddr (dm_waddr),
        .wdata (dm_wdata),
        .raddr (alu_y[AW+1:2]),
        .rdata (dm_rdata)
    );

    assign pc_seq  = pc_q + 32'd4;
    assign br_tgt  = pc_seq + br_off;
    assign jmp_tgt = {pc_seq[31:28], instr[25:0], 2'b00};

    // Pick the next PC: jump, taken branch, or sequential.
    always_comb begin
        if (ctrl.jump)                     pc_next = jmp_tgt;
        else if (ctrl.branch && alu_zero)  pc_next = br_tgt;
        else                               pc_next = pc_seq;
    end

    // Program counter register.
    always_ff @(posedge clk) begin
        if (!rst_n) pc_q <= '0;
        else        pc_q <= pc_next;
    end

    assign dbg_pc       = pc_q;
    assign dbg_rf_we    = rf_we;
    assign dbg_rf_waddr = rf_waddr;
    assign dbg_rf_wdata = wb_data;
    assign dbg_dm_we    = core_dm_we;
    assign dbg_dm_addr  = alu_y;
    assign dbg_dm_wdata = rt_val;

endmodule

// File: rtl/scyc_core_chk.sv
// Module scyc_core_chk: protocol checks on the core's debug outputs against
// the instruction being executed. Bound into scyc_core below.
module scyc_core_chk
    import scyc_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic [5:0]  opcode,
    input logic [4:0]  rt_fld,
    input logic [25:0] jidx,
    input logic [31:0] dbg_pc,
    input logic        dbg_rf_we,
    input logic [4:0]  dbg_rf_waddr,
    input logic        dbg_dm_we
);

    logic [31:0] seq_pc, jump_exp;
    assign seq_pc   = dbg_pc + 32'd4;
    assign jump_exp = {seq_pc[31:28], jidx, 2'b00};

    assert_pc_from_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> dbg_pc == 32'd0);

    assert_pc_aligned_R2: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_pc[1:0] == 2'b00);

    assert_seq_pc_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (opcode != OP_BREQ && opcode != OP_JUMP) |=> dbg_pc == $past(seq_pc));

    assert_load_dst_R6: assert property (@(posedge clk) disable iff (!rst_n)
        opcode == OP_LOADW |-> dbg_rf_we && dbg_rf_waddr == rt_fld);

    assert_store_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
        opcode == OP_STORW |-> dbg_dm_we && !dbg_rf_we);

    assert_jump_target_R9: assert property (@(posedge clk) disable iff (!rst_n)
        opcode == OP_JUMP |=> dbg_pc == $past(jump_exp));

    assert_write_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(dbg_rf_we && dbg_dm_we));

endmodule

bind scyc_core scyc_core_chk chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .opcode       (instr[31:26]),
    .rt_fld       (instr[20:16]),
    .jidx         (instr[25:0]),
    .dbg_pc       (dbg_pc),
    .dbg_rf_we    (dbg_rf_we),
    .dbg_rf_waddr (dbg_rf_waddr),
    .dbg_dm_we    (dbg_dm_we)
);

// File: tb/scyc_core_tb_top.sv
// Bench: loads a program and data during reset, then steps a behavioural
// instruction-level model once per clock and compares every debug output.
module scyc_core_tb_top;

    localparam int  WORDS = 64;
    localparam time CLK_T = 20ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load_en = 1'b0, load_dmem = 1'b0;
    logic [5:0]  load_addr = '0;
    logic [31:0] load_word = '0;
    logic [31:0] dbg_pc, dbg_rf_wdata, dbg_dm_addr, dbg_dm_wdata;
    logic        dbg_rf_we, dbg_dm_we;
    logic [4:0]  dbg_rf_waddr;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    logic [31:0] m_imem [WORDS];
    logic [31:0] m_dmem [WORDS];
    logic [31:0] m_reg  [32];
    logic [31:0] m_pc;

    always #(CLK_T/2) clk = ~clk;

    scyc_core #(.MEM_WORDS(WORDS)) dut_i (
        .clk, .rst_n, .load_en, .load_dmem, .load_addr, .load_word,
        .dbg_pc, .dbg_rf_we, .dbg_rf_waddr, .dbg_rf_wdata,
        .dbg_dm_we, .dbg_dm_addr, .dbg_dm_wdata
    );

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] enc_r(int rs, int rt, int rd, logic [5:0] fn);
        return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
    endfunction
    function automatic logic [31:0] enc_i(logic [5:0] op, int rs, int rt, int imm);
        return {op, 5'(rs), 5'(rt), 16'(imm)};
    endfunction
    function automatic logic [31:0] enc_j(int idx);
        return {6'h02, 26'(idx)};
    endfunction

    // Build the program and data image in the model.
    task automatic build_image();
        for (int i = 0; i < WORDS; i++) begin
            m_imem[i] = 32'h0;
            m_dmem[i] = 32'(i) * 32'h0101_0101 + 32'd3;
        end
        m_dmem[0] = 32'd8; m_dmem[1] = 32'hFFFF_FFFD;
        m_dmem[2] = 32'h0F0F_00FF; m_dmem[3] = 32'd32;
        m_imem[0]  = enc_i(6'h23, 0, 1, 0);
        m_imem[1]  = enc_i(6'h23, 0, 2, 4);
        m_imem[2]  = enc_i(6'h23, 0, 3, 8);
        m_imem[3]  = enc_i(6'h23, 0, 12, 12);
        m_imem[4]  = enc_r(1, 2, 4, 6'h20);
        m_imem[5]  = enc_r(1, 2, 5, 6'h22);
        m_imem[6]  = enc_r(3, 2, 6, 6'h24);
        m_imem[7]  = enc_r(3, 1, 7, 6'h25);
        m_imem[8]  = enc_r(2, 1, 8, 6'h2A);
        m_imem[9]  = enc_r(1, 2, 9, 6'h2A);
        m_imem[10] = enc_r(1, 1, 0, 6'h20);
        m_imem[11] = enc_r(0, 3, 10, 6'h20);
        m_imem[12] = enc_i(6'h2B, 12, 4, -8);
        m_imem[13] = enc_i(6'h23, 1, 11, 16);
        m_imem[14] = enc_i(6'h04, 4, 11, 1);
        m_imem[15] = enc_r(1, 1, 13, 6'h20);
        m_imem[16] = enc_i(6'h04, 1, 2, 5);
        m_imem[17] = enc_r(14, 8, 14, 6'h20);
        m_imem[18] = enc_r(14, 1, 15, 6'h2A);
        m_imem[19] = enc_i(6'h04, 15, 8, -3);
        m_imem[20] = 32'hFC22_3333;
        m_imem[21] = enc_r(1, 2, 20, 6'h03);
        m_imem[22] = enc_j(30);
        for (int i = 23; i < 30; i++) m_imem[i] = enc_r(1, 1, 13, 6'h20);
        m_imem[30] = enc_i(6'h2B, 12, 5, -4);
        m_imem[31] = enc_i(6'h23, 0, 16, 28);
        m_imem[32] = enc_j(32);
    endtask

    // One model step: compare the DUT's outputs for this cycle, then commit.
    task automatic step_and_compare();
        logic [31:0] ins, a, b, y, npc, seq;
        logic [5:0]  op, fn;
        logic        rwe, mwe;
        logic [4:0]  wa;
        string       tag, ptag;
        ins = m_imem[m_pc[7:2]];
        op = ins[31:26]; fn = ins[5:0];
        a = (ins[25:21] == 0) ? 32'h0 : m_reg[ins[25:21]];
        b = (ins[20:16] == 0) ? 32'h0 : m_reg[ins[20:16]];
        seq = m_pc + 4; npc = seq; rwe = 0; mwe = 0; wa = 0; y = 0;
        tag = "R10"; ptag = "R2";
        if (op == 6'h00) begin
            wa = ins[15:11]; rwe = 1; tag = "R3";
            case (fn)
                6'h20: y = a + b;
                6'h22: y = a - b;
                6'h24: y = a & b;
                6'h25: y = a | b;
                6'h2A: begin y = ($signed(a) < $signed(b)) ? 1 : 0; tag = "R4"; end
                default: begin rwe = 0; tag = "R10"; end
            endcase
            if (rwe && (ins[25:21] == 0 || ins[20:16] == 0 || wa == 0)) tag = "R5";
        end else if (op == 6'h23) begin
            y = a + {{16{ins[15]}}, ins[15:0]};
            rwe = 1; wa = ins[20:16]; tag = "R6";
        end else if (op == 6'h2B) begin
            y = a + {{16{ins[15]}}, ins[15:0]};
            mwe = 1; tag = "R7";
        end else if (op == 6'h04) begin
            tag = "R8"; ptag = "R8";
            if (a == b) npc = seq + {{14{ins[15]}}, ins[15:0], 2'b00};
        end else if (op == 6'h02) begin
            tag = "R9"; ptag = "R9";
            npc = {seq[31:28], ins[25:0], 2'b00};
        end
        chk(ptag, "pc", dbg_pc, m_pc);
        chk(tag, "rf_we", 32'(dbg_rf_we), 32'(rwe));
        chk(tag, "dm_we", 32'(dbg_dm_we), 32'(mwe));
        if (rwe) begin
            if (op == 6'h23) y = m_dmem[y[7:2]];
            chk(tag, "rf_waddr", 32'(dbg_rf_waddr), 32'(wa));
            chk(tag, "rf_wdata", dbg_rf_wdata, y);
            if (wa != 0) m_reg[wa] = y;
        end
        if (mwe) begin
            chk(tag, "dm_addr", dbg_dm_addr, y);
            chk(tag, "dm_wdata", dbg_dm_wdata, b);
            m_dmem[y[7:2]] = b;
        end
        m_pc = npc;
    endtask

    // Main sequence: load under reset, release, step the model every cycle.
    initial begin
        build_image();
        for (int i = 0; i < 32; i++) m_reg[i] = 32'h0;
        m_pc = 32'h0;
        for (int k = 0; k < 2 * WORDS; k++) begin
            @(negedge clk);
            load_en   = 1'b1;
            load_dmem = (k >= WORDS);
            load_addr = 6'(k % WORDS);
            load_word = (k >= WORDS) ? m_dmem[k - WORDS] : m_imem[k];
            #1;
            if (k % 16 == 0) begin
                chk("R1", "pc in reset", dbg_pc, 32'h0);
                chk("R1", "rf_we in reset", 32'(dbg_rf_we), 32'h0);
                chk("R1", "dm_we in reset", 32'(dbg_dm_we), 32'h0);
            end
        end
        @(negedge clk);
        load_en = 1'b0;
        rst_n   = 1'b1;
        for (int c = 0; c < 90; c++) begin
            #2;
            step_and_compare();
            @(negedge clk);
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(CLK_T * 20000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL R2 watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

endmodule